// File: doc/BRIEF.md
# Two-Wire Addressed 8-Pin I/O Expander

This block is a target on a two-wire serial bus that gives a bus master control of eight general-purpose pins. Each pin can be an input or an output. The master writes a command byte that selects one of four 8-bit registers, then writes data to that register or reads it back. The four registers are sampled input, output drive, input polarity and pin direction. A value read from the input register passes through the polarity mask bit by bit, so each input can be read back as active-high or active-low.

Both bus lines are oversampled by the system clock through a synchroniser of selectable depth. START and STOP are recognised from SDA edges while SCL is high. The target only ever pulls SDA low and never drives it high. Pin 0 is an open-drain output, and pins 1 to 7 drive both levels when they are outputs.

An active-low asynchronous reset puts every register back to its power-on value and returns the bus state machine to idle.

Top module: `i2c_gpio_expander`

## Requirements
- R1: After reset, the output register is 0x00, the polarity register is 0x00 and the direction register is 0xFF. As a result no pin is driven (`pin_oe` = 0x00) and SDA is released.
- R2: The 7-bit target address is {`ADDR_HI`, `addr_sel`}, with `ADDR_HI` default 4'b0011. The target acknowledges only on a full 7-bit match. On a mismatch it leaves SDA released and ignores all bytes until the next START.
- R3: In a write transaction, the first byte after the address is a command byte. Its bits [1:0] select the register: 0 input, 1 output, 2 polarity, 3 direction. Every later data byte of that transaction is written to the selected register, and the last one written wins.
- R4: A read transaction returns the selected register MSB first. While the master acknowledges, further bytes return the same register again. A master NACK ends the transfer with SDA released.
- R5: The input register captures `pin_i` at the address acknowledge of a read transaction. Pin changes after that point do not alter the byte being read.
- R6: Reading register 0 returns the captured inputs XOR the polarity register. Writes to register 0 have no effect.
- R7: A direction bit of 1 makes its pin an input (not driven). A direction bit of 0 makes it an output, and for pins 1 to 7 `pin_o` then carries the output register bit.
- R8: Pin 0 is open-drain. `pin_o[0]` is always 0. `pin_oe[0]` is 1 only when direction bit 0 is 0 and output bit 0 is 0.
- R9: Asserting `rst_n` low in the middle of a transaction restores the values of R1 and aborts the transfer. The next transaction then works normally.
- R10: The register selection persists across STOP, so a read-only transaction returns the register chosen by an earlier write. A repeated START restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_sel | input | 3 | Low three bits of the target address |
| pin_i | input | 8 | Levels seen on the eight pins |
| pin_o | output | 8 | Drive value for each pin |
| pin_oe | output | 8 | Drive enable for each pin |

## Verification
The bench builds the block with `ADDR_HI` left at 4'b0011, `SYNC_STAGES` raised to 3 and `addr_sel` tied to 3'b101. The deeper synchroniser lengthens the delay between an SCL fall and the target's SDA change. This shows whether acknowledge and read data still settle within the low phase. The chosen address lets the bench miss the target in the pin-selected bits and in the fixed upper bits separately. The pin values are changed between the address acknowledge and the data clocks to probe when the input capture happens.

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander #(
  parameter logic [3:0] ADDR_HI     = 4'b0011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] addr_sel,
  input  logic [7:0] pin_i,
  output logic [7:0] pin_o,
  output logic [7:0] pin_oe
);
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WDATA, S_WACK, S_RDATA, S_RACK
  } st_t;

  st_t st;
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, rnw, mnack;
  logic [CW-1:0] bitcnt;
  logic [W-1:0] shreg, txsh, rdval;
  logic [W-1:0] in_reg, out_reg, pol_reg, cfg_reg;
  logic [1:0] ptr;

  wire scl_s     = scl_sh[SYNC_STAGES-1];
  wire sda_s     = sda_sh[SYNC_STAGES-1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire last8     = (bitcnt == LAST);
  wire addr_hit  = (shreg[W-1:1] == {ADDR_HI, addr_sel});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end

  always_comb
    case (ptr)
      2'd0:    rdval = in_reg ^ pol_reg;
      2'd1:    rdval = out_reg;
      2'd2:    rdval = pol_reg;
      default: rdval = cfg_reg;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      sda_oe  <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      txsh    <= '0;
      rnw     <= 1'b0;
      mnack   <= 1'b0;
      ptr     <= 2'd0;
      in_reg  <= '0;
      out_reg <= '0;
      pol_reg <= '0;
      cfg_reg <= '1;
    end else if (start_det) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      if (scl_rise) begin
        shreg <= {shreg[W-2:0], sda_s};
        if (!last8) bitcnt <= bitcnt + 1'b1;
        if (st == S_RACK) mnack <= sda_s;
      end
      if (scl_fall)
        case (st)
          S_ADDR:
            if (last8) begin
              if (addr_hit) begin
                sda_oe <= 1'b1;
                rnw    <= shreg[0];
                st     <= S_AACK;
                if (shreg[0]) in_reg <= pin_i;
              end else
                st <= S_IDLE;
            end
          S_AACK: begin
            bitcnt <= '0;
            if (rnw) begin
              txsh   <= rdval;
              sda_oe <= ~rdval[W-1];
              st     <= S_RDATA;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_CMD;
            end
          end
          S_CMD:
            if (last8) begin
              ptr    <= shreg[1:0];
              sda_oe <= 1'b1;
              st     <= S_CACK;
            end
          S_CACK, S_WACK: begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st     <= S_WDATA;
          end
          S_WDATA:
            if (last8) begin
              case (ptr)
                2'd1:    out_reg <= shreg;
                2'd2:    pol_reg <= shreg;
                2'd3:    cfg_reg <= shreg;
                default: ;
              endcase
              sda_oe <= 1'b1;
              st     <= S_WACK;
            end
          S_RDATA:
            if (last8) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
            end else begin
              txsh   <= {txsh[W-2:0], 1'b0};
              sda_oe <= ~txsh[W-2];
            end
          S_RACK:
            if (mnack)
              st <= S_IDLE;
            else begin
              txsh   <= rdval;
              sda_oe <= ~rdval[W-1];
              bitcnt <= '0;
              st     <= S_RDATA;
            end
          default: ;
        endcase
    end

  assign pin_o  = {out_reg[W-1:1], 1'b0};
  assign pin_oe = {~cfg_reg[W-1:1], ~cfg_reg[0] & ~out_reg[0]};

  // R1
  reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_reg == 8'hFF && out_reg == 8'h00 && pol_reg == 8'h00 && !sda_oe));

  // R2
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  // R4
  sda_moves_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R5
  capture_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_reg) |-> $past(st == S_ADDR && scl_fall && last8 && addr_hit));

  // R3
  dir_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_reg) |-> $past(st == S_WDATA && scl_fall && last8 && ptr == 2'd3));

  // R8
  pin0_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[0] |-> (!cfg_reg[0] && !pin_o[0]));
endmodule

// File: tb/test_i2c_gpio_expander.sv
module test_i2c_gpio_expander;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [6:0] DEV = {4'b0011, SEL};

  // vector: [25:24] register, [23:16] write value, [15:8] pins, [7:0] expected read
  localparam logic [25:0] VEC [8] = '{
    {2'd3, 8'h00, 8'h00, 8'h00},
    {2'd1, 8'hA5, 8'h00, 8'hA5},
    {2'd2, 8'h0F, 8'h00, 8'h0F},
    {2'd0, 8'hFF, 8'h3C, 8'h33},
    {2'd2, 8'h00, 8'h3C, 8'h00},
    {2'd0, 8'h00, 8'hC3, 8'hC3},
    {2'd3, 8'hF0, 8'hC3, 8'hF0},
    {2'd1, 8'h5A, 8'hC3, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic [7:0] pin_i = 8'h00;
  logic sda_oe;
  logic [7:0] pin_o, pin_oe;
  wire sda_line = ~(m_sda_low | sda_oe);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic ackv;
  logic [7:0] got, got2;

  i2c_gpio_expander #(.ADDR_HI(4'b0011), .SYNC_STAGES(3)) i_i2c_gpio_expander (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(SEL), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_scl = 1'b0; hold();
    m_sda_low = 1'b0; hold();
    m_scl = 1'b1; hold();
    m_sda_low = 1'b1; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; m_sda_low = 1'b1; hold();
    m_scl = 1'b1; hold();
    m_sda_low = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; hold();
      m_scl = 1'b1; hold();
      m_scl = 1'b0;
    end
    m_sda_low = 1'b0; hold();
    m_scl = 1'b1;
    repeat (Q / 2) @(negedge clk);
    ackv = ~sda_line;
    repeat (Q - Q / 2) @(negedge clk);
    m_scl = 1'b0; hold();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    m_sda_low = 1'b0;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      hold();
      m_scl = 1'b1;
      repeat (Q / 2) @(negedge clk);
      b = {b[6:0], sda_line};
      repeat (Q - Q / 2) @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda_low = ack; hold();
    m_scl = 1'b1; hold();
    m_scl = 1'b0; m_sda_low = 1'b0; hold();
  endtask

  task automatic wr_reg(input logic [1:0] r, input logic [7:0] v);
    bus_start();
    send_byte({DEV, 1'b0});
    send_byte({6'd0, r});
    send_byte(v);
    bus_stop();
  endtask

  task automatic rd_reg(input logic [1:0] r, output logic [7:0] v);
    bus_start();
    send_byte({DEV, 1'b0});
    send_byte({6'd0, r});
    bus_start();
    send_byte({DEV, 1'b1});
    recv_byte(1'b0, v);
    bus_stop();
  endtask

  task automatic do_reset();
    m_scl = 1'b1; m_sda_low = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state at the ports and through reads
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    rd_reg(2'd3, got); chk("R1 direction", got, 8'hFF);
    rd_reg(2'd1, got); chk("R1 output", got, 8'h00);
    rd_reg(2'd2, got); chk("R1 polarity", got, 8'h00);

    for (int k = 0; k < 8; k++) begin
      pin_i = VEC[k][15:8];
      wr_reg(VEC[k][25:24], VEC[k][23:16]);
      rd_reg(VEC[k][25:24], got);
      chk(VEC[k][25:24] == 2'd0 ? "R6 input read" : "R3 register write", got, VEC[k][7:0]);
    end

    // R7 direction F0, output 5A
    chk("R7 pin_oe", pin_oe, 8'h0F);
    chk("R7 pin_o", pin_o, 8'h5A);

    // R8 open-drain pin 0
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd1, 8'h01);
    chk("R8 oe released on 1", pin_oe, 8'hFE);
    chk("R8 pin_o low", pin_o, 8'h00);
    wr_reg(2'd1, 8'h80);
    chk("R8 oe pulls on 0", pin_oe, 8'hFF);
    chk("R7 pin_o push-pull", pin_o, 8'h80);

    // R3 several data bytes land in one register
    bus_start();
    send_byte({DEV, 1'b0});
    send_byte(8'h01);
    send_byte(8'hA1);
    send_byte(8'hB2);
    bus_stop();
    rd_reg(2'd1, got); chk("R3 last byte wins", got, 8'hB2);

    // R2 address mismatch in selected bits and in fixed bits
    bus_start();
    send_byte({4'b0011, 3'b010, 1'b0});
    chk("R2 nack low bits", {7'd0, ackv}, 8'h00);
    send_byte(8'h01);
    send_byte(8'h77);
    bus_stop();
    bus_start();
    send_byte({4'b0111, SEL, 1'b0});
    chk("R2 nack high bits", {7'd0, ackv}, 8'h00);
    send_byte(8'h01);
    send_byte(8'h66);
    bus_stop();
    rd_reg(2'd1, got); chk("R2 ignored write", got, 8'hB2);
    bus_start();
    send_byte({DEV, 1'b0});
    chk("R2 ack on match", {7'd0, ackv}, 8'h01);
    bus_stop();

    // R4 multi-byte read
    wr_reg(2'd1, 8'h3E);
    bus_start();
    send_byte({DEV, 1'b0});
    send_byte(8'h01);
    bus_start();
    send_byte({DEV, 1'b1});
    recv_byte(1'b1, got);
    recv_byte(1'b0, got2);
    chk("R4 first byte", got, 8'h3E);
    chk("R4 repeated byte", got2, 8'h3E);
    chk("R4 sda released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();

    // R5 capture at address acknowledge
    wr_reg(2'd2, 8'h81);
    pin_i = 8'h55;
    bus_start();
    send_byte({DEV, 1'b0});
    send_byte(8'h00);
    bus_start();
    send_byte({DEV, 1'b1});
    pin_i = 8'hAA;
    recv_byte(1'b0, got);
    bus_stop();
    chk("R5 captured value", got, 8'hD4);
    rd_reg(2'd0, got); chk("R5 new capture", got, 8'h2B);

    // R6 write to input register ignored
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, got); chk("R6 write ignored", got, 8'h2B);

    // R10 selection kept across STOP, read-only transaction
    bus_start();
    send_byte({DEV, 1'b0});
    send_byte(8'h02);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1});
    recv_byte(1'b0, got);
    bus_stop();
    chk("R10 pointer kept", got, 8'h81);

    // R9 reset during a data byte
    bus_start();
    send_byte({DEV, 1'b0});
    send_byte(8'h01);
    for (int i = 7; i >= 4; i--) begin
      m_sda_low = ~i[0]; hold();
      m_scl = 1'b1; hold();
      m_scl = 1'b0;
    end
    do_reset();
    chk("R9 pins released", pin_oe, 8'h00);
    chk("R9 sda released", {7'd0, sda_oe}, 8'h00);
    rd_reg(2'd1, got); chk("R9 output default", got, 8'h00);
    rd_reg(2'd2, got); chk("R9 polarity default", got, 8'h00);
    rd_reg(2'd3, got); chk("R9 direction default", got, 8'hFF);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule